// File: doc/BRIEF.md
# Global Command and Status Handler for a DMA-Remapping Unit

This block holds the global command and global status register pair of a DMA-remapping unit. When software writes a command word, the block XORs it with the current status. It then carries out only the actions whose capability input is present. Two actions exist. The first turns queued invalidation on or off; turning it off also clears the invalidation queue head. The second is a set-pointer command. It copies the software-visible interrupt-remapping table address into an active shadow copy and reports the copy in a status bit.

The software-visible table address can be rewritten at any time. The remapping logic sees only the active copy, which changes only on a set-pointer command. The queue engine keeps the head pointer moving through its own update port. Every action is registered, so results appear one clock after the write.

Top module: `gcs_cmd_status`

## Requirements
- R1: After reset, `status`, `cmd_rd`, `queue_head`, `tbl_addr_raw` and `tbl_addr_active` all read zero.
- R2: A command write that has bit 26 (queue enable) different from status bit 26 while `cap_qinval` is 1 sets status bit 26 to the written value on the next clock.
- R3: When the R2 action turns queue enable off, `queue_head` reads zero on the next clock.
- R4: When `cap_qinval` is 0, a command write changes neither status bit 26 nor `queue_head`.
- R5: A command write whose bit 26 equals status bit 26 does not clear `queue_head`.
- R6: A command write with bit 24 (set pointer) set while `cap_irmap` is 1 copies `tbl_addr_raw` into `tbl_addr_active` and sets status bit 24 on the next clock. Status bit 26 is left unchanged, and status bit 24 stays set until reset.
- R7: A write to `tbl_addr_raw` without a set-pointer command leaves `tbl_addr_active` unchanged.
- R8: When `cap_irmap` is 0, a set-pointer command changes neither `tbl_addr_active` nor status bit 24.
- R9: `cmd_rd` returns the last written command word with bit 24 forced to zero.
- R10: `head_upd_en` loads `head_upd_val` into `queue_head`. A same-cycle disable clear takes priority over the load.
- R11: If the table address is written in the same cycle as a set-pointer command, the active copy takes the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 32 | Command word written |
| cap_qinval | input | 1 | Queued invalidation supported |
| cap_irmap | input | 1 | Interrupt remapping supported |
| tbl_wr_en | input | 1 | Raw table-address write strobe |
| tbl_wr_data | input | ADDR_W | Raw table-address write value |
| head_upd_en | input | 1 | Queue engine head update strobe |
| head_upd_val | input | HEAD_W | New queue head value |
| cmd_rd | output | 32 | Command register read value |
| status | output | 32 | Global status (bit 26 queue enabled, bit 24 pointer latched) |
| queue_head | output | HEAD_W | Invalidation queue head |
| tbl_addr_raw | output | ADDR_W | Software-visible table address |
| tbl_addr_active | output | ADDR_W | Active table address used by remapping |

## Verification
Some rules are checked by assertions on every clock. Status bit 26 holds whenever no capable write occurs. The head is zero after a disable. The active table copy moves only on a capable set-pointer command, and it always takes the previous raw value. The pointer status bit never drops, and the one-shot bit never reads back. Other behaviour needs the bench's scenarios: rewriting the current enable value so that no clear happens, priority between a clear and a head update, and long random mixes of capability settings checked against a reference model.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int CMD_W      = 32;
  localparam int QIE_BIT    = 26;
  localparam int SETPTR_BIT = 24;
  localparam logic [CMD_W-1:0] ONESHOT_MASK = CMD_W'(1) << SETPTR_BIT;
endpackage

// File: rtl/gcs_qi_ctrl.sv
module gcs_qi_ctrl #(
  parameter int HEAD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              cap_qi,
  input  logic              qie_changed,
  input  logic              qie_new,
  input  logic              head_upd_en,
  input  logic [HEAD_W-1:0] head_upd_val,
  output logic              qie_sts,
  output logic [HEAD_W-1:0] head
);
  logic act;
  assign act = wr_en & cap_qi & qie_changed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qie_sts <= 1'b0;
      head    <= '0;
    end else begin
      if (act) qie_sts <= qie_new;
      if (act && !qie_new) head <= '0;
      else if (head_upd_en) head <= head_upd_val;
    end
  end

  assert_head_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cap_qi && qie_sts && !qie_new) |=> (head == '0) && !qie_sts);
  assert_qie_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cap_qi) |=> $stable(qie_sts));
  assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_upd_en && !(wr_en && cap_qi && qie_sts && !qie_new)) |=> $stable(head));
endmodule

// File: rtl/gcs_ptr_latch.sv
module gcs_ptr_latch #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              setptr,
  input  logic              cap_ir,
  input  logic              raw_wr_en,
  input  logic [ADDR_W-1:0] raw_wr_data,
  output logic [ADDR_W-1:0] raw,
  output logic [ADDR_W-1:0] active,
  output logic              tps
);
  logic fire;
  assign fire = wr_en & cap_ir & setptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw    <= '0;
      active <= '0;
      tps    <= 1'b0;
    end else begin
      if (raw_wr_en) raw <= raw_wr_data;
      if (fire) begin
        active <= raw;
        tps    <= 1'b1;
      end
    end
  end

  assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cap_ir && setptr) |=> tps && (active == $past(raw)));
  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cap_ir && setptr) |=> $stable(active));
  assert_tps_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tps |=> tps);
endmodule

// File: rtl/gcs_cmd_status.sv
module gcs_cmd_status #(
  parameter int HEAD_W = 16,
  parameter int ADDR_W = 48
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_wr_en,
  input  logic [gcs_pkg::CMD_W-1:0]  cmd_wr_data,
  input  logic                       cap_qinval,
  input  logic                       cap_irmap,
  input  logic                       tbl_wr_en,
  input  logic [ADDR_W-1:0]          tbl_wr_data,
  input  logic                       head_upd_en,
  input  logic [HEAD_W-1:0]          head_upd_val,
  output logic [gcs_pkg::CMD_W-1:0]  cmd_rd,
  output logic [gcs_pkg::CMD_W-1:0]  status,
  output logic [HEAD_W-1:0]          queue_head,
  output logic [ADDR_W-1:0]          tbl_addr_raw,
  output logic [ADDR_W-1:0]          tbl_addr_active
);
  import gcs_pkg::*;

  logic [CMD_W-1:0] changed;
  logic             qie_sts;
  logic             tps;

  assign changed = status ^ cmd_wr_data;

  always_comb begin
    status             = '0;
    status[QIE_BIT]    = qie_sts;
    status[SETPTR_BIT] = tps;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_rd <= '0;
    else if (cmd_wr_en) cmd_rd <= cmd_wr_data & ~ONESHOT_MASK;
  end

  gcs_qi_ctrl #(.HEAD_W(HEAD_W)) u_qi (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr_en), .cap_qi(cap_qinval),
    .qie_changed(changed[QIE_BIT]), .qie_new(cmd_wr_data[QIE_BIT]),
    .head_upd_en(head_upd_en), .head_upd_val(head_upd_val),
    .qie_sts(qie_sts), .head(queue_head)
  );

  gcs_ptr_latch #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr_en),
    .setptr(cmd_wr_data[SETPTR_BIT]), .cap_ir(cap_irmap),
    .raw_wr_en(tbl_wr_en), .raw_wr_data(tbl_wr_data),
    .raw(tbl_addr_raw), .active(tbl_addr_active), .tps(tps)
  );

  assert_cmd_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_en |=> !cmd_rd[SETPTR_BIT] && (cmd_rd[QIE_BIT] == $past(cmd_wr_data[QIE_BIT])));
endmodule

// File: tb/sim_gcs_cmd_status.sv
module sim_gcs_cmd_status;
  localparam int HEAD_W = 16;
  localparam int ADDR_W = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr_en = 1'b0;
  logic [31:0] cmd_wr_data = '0;
  logic cap_qinval = 1'b1, cap_irmap = 1'b1;
  logic tbl_wr_en = 1'b0;
  logic [ADDR_W-1:0] tbl_wr_data = '0;
  logic head_upd_en = 1'b0;
  logic [HEAD_W-1:0] head_upd_val = '0;
  logic [31:0] cmd_rd, status;
  logic [HEAD_W-1:0] queue_head;
  logic [ADDR_W-1:0] tbl_addr_raw, tbl_addr_active;

  int checks = 0;
  int errors = 0;
  logic m_qie, m_tps;
  logic [HEAD_W-1:0] m_head;
  logic [ADDR_W-1:0] m_raw, m_act;
  logic [31:0] m_cmd;

  always #10 clk = ~clk;

  gcs_cmd_status #(.HEAD_W(HEAD_W), .ADDR_W(ADDR_W)) u0 (.*);

  function automatic logic [31:0] exp_status(logic q, logic t);
    return (32'(q) << 26) | (32'(t) << 24);
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "status", 64'(status), 64'(exp_status(m_qie, m_tps)));
    check(tag, "head", 64'(queue_head), 64'(m_head));
    check(tag, "active", 64'(tbl_addr_active), 64'(m_act));
    check(tag, "raw", 64'(tbl_addr_raw), 64'(m_raw));
    check(tag, "cmd_rd", 64'(cmd_rd), 64'(m_cmd));
  endtask

  // Inputs already set at a negedge; update model, cross one posedge, compare.
  task automatic step(string tag);
    logic clr, fire;
    clr  = cmd_wr_en && cap_qinval && (m_qie != cmd_wr_data[26]) && !cmd_wr_data[26];
    fire = cmd_wr_en && cap_irmap && cmd_wr_data[24];
    if (clr) m_head = '0;
    else if (head_upd_en) m_head = head_upd_val;
    if (cmd_wr_en && cap_qinval && (m_qie != cmd_wr_data[26])) m_qie = cmd_wr_data[26];
    if (fire) begin m_act = m_raw; m_tps = 1'b1; end
    if (tbl_wr_en) m_raw = tbl_wr_data;
    if (cmd_wr_en) m_cmd = cmd_wr_data & ~(32'd1 << 24);
    @(negedge clk);
    compare(tag);
    cmd_wr_en = 0; tbl_wr_en = 0; head_upd_en = 0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_qie = 0; m_tps = 0; m_head = '0; m_raw = '0; m_act = '0; m_cmd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");

    // R2 enable, R10 head load
    cmd_wr_en = 1; cmd_wr_data = 32'h0400_0000; step("R2");
    head_upd_en = 1; head_upd_val = 16'h0140; step("R10");
    // R5 rewrite same enable value: head kept
    cmd_wr_en = 1; cmd_wr_data = 32'h0400_0003; step("R5");
    // R4 no capability: disable ignored
    cap_qinval = 0; cmd_wr_en = 1; cmd_wr_data = 32'h0; step("R4");
    cap_qinval = 1;
    // R3 + R10 priority: disable with simultaneous head update
    cmd_wr_en = 1; cmd_wr_data = 32'h0; head_upd_en = 1; head_upd_val = 16'h0BEE; step("R3");
    // R7 raw write alone
    tbl_wr_en = 1; tbl_wr_data = 48'h1234_5678_9000; step("R7");
    // R6 set pointer, R9 readback hides one-shot bit
    cmd_wr_en = 1; cmd_wr_data = 32'h0100_0010; step("R6");
    check("R9", "oneshot", 64'(cmd_rd[24]), 64'd0);
    // R11 same-cycle raw write and set pointer
    tbl_wr_en = 1; tbl_wr_data = 48'hAAAA_0000_F000;
    cmd_wr_en = 1; cmd_wr_data = 32'h0100_0000; step("R11");
    // R8 no interrupt-remapping capability
    cap_irmap = 0; tbl_wr_en = 1; tbl_wr_data = 48'h0000_0000_5000; step("R7");
    cmd_wr_en = 1; cmd_wr_data = 32'h0500_0000; step("R8");
    cap_irmap = 1;

    for (int i = 0; i < 3000; i++) begin
      cap_qinval   = ($urandom % 8) != 0;
      cap_irmap    = ($urandom % 8) != 0;
      cmd_wr_en    = ($urandom % 2) == 0;
      cmd_wr_data  = $urandom;
      tbl_wr_en    = ($urandom % 3) == 0;
      tbl_wr_data  = {16'($urandom), 32'($urandom)};
      head_upd_en  = ($urandom % 3) == 0;
      head_upd_val = 16'($urandom);
      step("R2_R3_R6_R9_R10_random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule